// File: doc/BRIEF.md
# Lazy Block-Clear Pointer Table

This block is a table of small pointers indexed by a 16-bit key. At the start of every event, every entry must read as zero. A full sweep of 65536 entries would take far too long between events, so the table never sweeps. It splits the key space into groups of 32 neighbouring entries and keeps one "touched" flag per group in a register file. The flags are cleared in a single cycle by a start-of-event pulse.

On the first write into a group whose flag is clear, the whole 320-bit row of that group is rewritten through a wide write path. The row holds zeros in 31 slots and the new pointer in the addressed slot, and the group's flag is set in the same cycle. Later writes to a touched group update only their own slot. A read from an untouched group returns zero no matter what the storage holds. Data left over from earlier events is therefore never visible.

The key splits into a group index (key[15:5]) and a slot within the group (key[4:0]). Reads have a latency of one cycle and a read-before-write ordering.

Top module: `lazy_clear_table`

## Requirements
- R1: After reset, every key reads 0, and rd_valid is low while no read has been issued.
- R2: A read issued with rd_en in one cycle raises rd_valid exactly one clock later and returns the value last written to that key in the current event. rd_valid stays low in cycles that follow no read.
- R3: A key with no write since the current event began reads 0. This includes keys that share a group with a written key. The group index is key[15:5] and the slot is key[4:0].
- R4: A start-of-event pulse (sof high for one cycle) makes every key read 0 afterwards. A write in the very next cycle is accepted.
- R5: A write presented in the same cycle as sof has no effect. A read presented in that cycle returns 0 with rd_valid set one cycle later.
- R6: The first write into an untouched group stores its value. The other 31 slots of that group read 0 even if they held data in an earlier event.
- R7: When a read and a write target the same key in the same cycle, the read returns the value held before that write. This is 0 if the group was untouched.
- R8: Further writes into a touched group change only their own slot. Rewriting a key keeps the latest value.
- R9: Writes into one group leave keys in every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sof | input | 1 | Start-of-event pulse; clears all group flags |
| wr_en | input | 1 | Write strobe |
| wr_key | input | 16 | Write key |
| wr_data | input | 10 | Pointer value to store |
| rd_en | input | 1 | Read strobe |
| rd_key | input | 16 | Read key |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_data | output | 10 | Read result |

## Verification
A first-touch write, which clears a whole group and stores one slot, can fall in the same cycle as a read of that group. The same is true of the start-of-event pulse together with a write or a read. The bench provokes both situations on purpose: it reads the key being written, or a neighbour of it, and it issues sof alongside accesses. It also interleaves these cases in a long random run over a few groups with occasional event starts. Each result is judged against a bench model of pointer values per key. The model applies the write after it forms the read's expected value, and it drops all entries on sof.

// File: rtl/lazy_clear_pkg.sv
package lazy_clear_pkg;
  parameter int unsigned KEY_W  = 16;
  parameter int unsigned DATA_W = 10;
  parameter int unsigned SLOT_W = 5;
  localparam int unsigned GRP_W = KEY_W - SLOT_W;
  localparam int unsigned SLOTS = 1 << SLOT_W;
  localparam int unsigned NGRP  = 1 << GRP_W;
  localparam int unsigned ROW_W = SLOTS * DATA_W;
endpackage

// File: rtl/lazy_clear_flags.sv
module lazy_clear_flags #(
  parameter int unsigned GRP_W = 11,
  localparam int unsigned NGRP = 1 << GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             set_en,
  input  logic [GRP_W-1:0] set_idx,
  input  logic [GRP_W-1:0] look_a,
  input  logic [GRP_W-1:0] look_b,
  output logic             hit_a,
  output logic             hit_b,
  output logic [NGRP-1:0]  flags
);
  logic [NGRP-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clr_all) flags_d = '0;
    else if (set_en) flags_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (clr_all || set_en) flags_q <= flags_d;
  end

  assign hit_a = flags_q[look_a];
  assign hit_b = flags_q[look_b];
  assign flags = flags_q;
endmodule

// File: rtl/lazy_clear_rows.sv
module lazy_clear_rows #(
  parameter int unsigned GRP_W  = 11,
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned DATA_W = 10,
  localparam int unsigned NGRP  = 1 << GRP_W,
  localparam int unsigned ROW_W = SLOTS * DATA_W
) (
  input  logic             clk,
  input  logic [SLOTS-1:0] wr_mask,
  input  logic [GRP_W-1:0] wr_row,
  input  logic [ROW_W-1:0] wr_word,
  input  logic             rd_en,
  input  logic [GRP_W-1:0] rd_row,
  output logic [ROW_W-1:0] rd_word
);
  logic [ROW_W-1:0] mem [NGRP];

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (wr_mask[s]) mem[wr_row][s*DATA_W +: DATA_W] <= wr_word[s*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_row];
  end
endmodule

// File: rtl/lazy_clear_table.sv
module lazy_clear_table
  import lazy_clear_pkg::*;
#(
  parameter int unsigned P_KEY_W  = KEY_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_SLOT_W = SLOT_W,
  localparam int unsigned L_GRP_W = P_KEY_W - P_SLOT_W,
  localparam int unsigned L_SLOTS = 1 << P_SLOT_W,
  localparam int unsigned L_NGRP  = 1 << L_GRP_W,
  localparam int unsigned L_ROW_W = L_SLOTS * P_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sof,
  input  logic                wr_en,
  input  logic [P_KEY_W-1:0]  wr_key,
  input  logic [P_DATA_W-1:0] wr_data,
  input  logic                rd_en,
  input  logic [P_KEY_W-1:0]  rd_key,
  output logic                rd_valid,
  output logic [P_DATA_W-1:0] rd_data
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [L_GRP_W-1:0]  wr_grp, rd_grp;
  logic [P_SLOT_W-1:0] wr_slot, rd_slot;
  assign wr_grp  = wr_key[P_KEY_W-1:P_SLOT_W];
  assign wr_slot = wr_key[P_SLOT_W-1:0];
  assign rd_grp  = rd_key[P_KEY_W-1:P_SLOT_W];
  assign rd_slot = rd_key[P_SLOT_W-1:0];

  logic wr_go, rd_go, first_touch;
  logic wr_grp_hit, rd_grp_hit;
  logic [L_NGRP-1:0] dirty_vec;

  assign wr_go       = wr_en && !sof;
  assign rd_go       = rd_en && !sof;
  assign first_touch = wr_go && !wr_grp_hit;

  lazy_clear_flags #(.GRP_W(L_GRP_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr_all (sof),
    .set_en  (first_touch),
    .set_idx (wr_grp),
    .look_a  (wr_grp),
    .look_b  (rd_grp),
    .hit_a   (wr_grp_hit),
    .hit_b   (rd_grp_hit),
    .flags   (dirty_vec)
  );

  // wide write word: new value in its slot, zero elsewhere
  logic [L_ROW_W-1:0] wr_word;
  logic [L_SLOTS-1:0] wr_mask;
  for (genvar s = 0; s < L_SLOTS; s++) begin : g_slot
    assign wr_word[s*P_DATA_W +: P_DATA_W] = (wr_slot == P_SLOT_W'(s)) ? wr_data : '0;
    assign wr_mask[s] = first_touch || (wr_go && (wr_slot == P_SLOT_W'(s)));
  end

  logic [L_ROW_W-1:0] rd_word;
  lazy_clear_rows #(.GRP_W(L_GRP_W), .SLOTS(L_SLOTS), .DATA_W(P_DATA_W)) u_rows (
    .clk     (clk),
    .wr_mask (wr_mask),
    .wr_row  (wr_grp),
    .wr_word (wr_word),
    .rd_en   (rd_go),
    .rd_row  (rd_grp),
    .rd_word (rd_word)
  );

  // read-side pipeline registers
  logic                rd_valid_q, rd_hit_q, rd_hit_d;
  logic [P_SLOT_W-1:0] rd_slot_q;
  assign rd_hit_d = rd_go && rd_grp_hit;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_valid_q <= 1'b0;
      rd_hit_q   <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      rd_hit_q   <= rd_hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   rd_slot_q <= '0;
    else if (rd_go) rd_slot_q <= rd_slot;
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_hit_q ? rd_word[rd_slot_q*P_DATA_W +: P_DATA_W] : '0;
endmodule

// File: rtl/lazy_clear_table_chk.sv
module lazy_clear_table_chk #(
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned SLOT_W = 5,
  localparam int unsigned NGRP  = 1 << (KEY_W - SLOT_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sof,
  input logic              wr_en,
  input logic [KEY_W-1:0]  wr_key,
  input logic              rd_en,
  input logic [KEY_W-1:0]  rd_key,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [NGRP-1:0]   dirty_vec
);
  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R4
  sof_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (dirty_vec == '0));
  // R5
  sof_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (rd_data == '0));
  // R6
  first_touch_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sof) |=> dirty_vec[$past(wr_key[KEY_W-1:SLOT_W])]);
  // R3
  untouched_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !dirty_vec[rd_key[KEY_W-1:SLOT_W]]) |=> (rd_data == '0));
endmodule

bind lazy_clear_table lazy_clear_table_chk #(
  .KEY_W(P_KEY_W), .DATA_W(P_DATA_W), .SLOT_W(P_SLOT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .sof       (sof),
  .wr_en     (wr_en),
  .wr_key    (wr_key),
  .rd_en     (rd_en),
  .rd_key    (rd_key),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .dirty_vec (dirty_vec)
);

// File: tb/lazy_clear_table_test.sv
module lazy_clear_table_test;
  logic        clk = 1'b0;
  logic        rst_n, sof, wr_en, rd_en;
  logic [15:0] wr_key, rd_key;
  logic [9:0]  wr_data;
  logic        rd_valid;
  logic [9:0]  rd_data;

  always #4 clk = ~clk;

  lazy_clear_table uut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .wr_en(wr_en), .wr_key(wr_key),
    .wr_data(wr_data), .rd_en(rd_en), .rd_key(rd_key),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  logic [9:0] model [int];
  logic [9:0] exp_q [$];
  string      tag_q [$];

  function automatic logic [9:0] lookup(logic [15:0] k);
    return model.exists(int'(k)) ? model[int'(k)] : 10'd0;
  endfunction

  task automatic step(bit s, bit w, logic [15:0] wk, logic [9:0] wd,
                      bit r, logic [15:0] rk, string tag);
    @(negedge clk);
    sof = s; wr_en = w; wr_key = wk; wr_data = wd; rd_en = r; rd_key = rk;
    if (r) begin
      exp_q.push_back(s ? 10'd0 : lookup(rk));
      tag_q.push_back(tag);
    end
    if (s) model.delete();
    else if (w) model[int'(wk)] = wd;
  endtask

  task automatic idle();
    step(0, 0, 16'h0, 10'h0, 0, 16'h0, "");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: rd_valid without read, actual=1 expected=0");
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: rd_data actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sof = 0; wr_en = 0; rd_en = 0;
    wr_key = '0; rd_key = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin
      fails++; $display("FAIL R1: rd_valid in reset actual=%b expected=0", rd_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1: fresh table reads zero
    step(0, 0, 0, 0, 1, 16'h0000, "R1");
    step(0, 0, 0, 0, 1, 16'hFFFF, "R1");
    step(0, 0, 0, 0, 1, 16'h4321, "R1");
    idle();
    // R2: write then read
    step(0, 1, 16'h1234, 10'h155, 0, 0, "");
    step(0, 0, 0, 0, 1, 16'h1234, "R2");
    // R3: neighbour in the same group, and another group
    step(0, 0, 0, 0, 1, 16'h1235, "R3");
    step(0, 0, 0, 0, 1, 16'h1220, "R3");
    step(0, 0, 0, 0, 1, 16'h5234, "R3");
    // R8: second write to touched group, overwrite
    step(0, 1, 16'h1230, 10'h0AA, 0, 0, "");
    step(0, 1, 16'h1234, 10'h3FF, 1, 16'h1230, "R8");
    step(0, 0, 0, 0, 1, 16'h1234, "R8");
    // R9: other group write leaves first group alone
    step(0, 1, 16'h8000, 10'h001, 0, 0, "");
    step(0, 0, 0, 0, 1, 16'h1230, "R9");
    step(0, 0, 0, 0, 1, 16'h8000, "R9");
    // fill a whole group to leave stale data
    for (int i = 0; i < 32; i++) step(0, 1, 16'h0A40 + 16'(i), 10'(i + 7), 0, 0, "");
    step(0, 0, 0, 0, 1, 16'h0A5F, "R2");
    // R4: event start, then write immediately after
    step(1, 0, 0, 0, 0, 0, "");
    step(0, 1, 16'h0A45, 10'h2C3, 1, 16'h1234, "R4");
    step(0, 0, 0, 0, 1, 16'h0A45, "R4");
    // R6: stale neighbours must read zero
    step(0, 0, 0, 0, 1, 16'h0A44, "R6");
    step(0, 0, 0, 0, 1, 16'h0A5F, "R6");
    step(0, 0, 0, 0, 1, 16'h8000, "R4");
    // R5: write and read in the sof cycle
    step(1, 1, 16'h0A46, 10'h111, 1, 16'h0A45, "R5");
    step(0, 0, 0, 0, 1, 16'h0A46, "R5");
    step(0, 0, 0, 0, 1, 16'h0A45, "R5");
    // R7: same-cycle read and write, untouched then touched group
    step(0, 1, 16'h0A47, 10'h0F0, 1, 16'h0A47, "R7");
    step(0, 1, 16'h0A47, 10'h00F, 1, 16'h0A47, "R7");
    step(0, 1, 16'h7771, 10'h123, 1, 16'h7772, "R7");
    step(0, 0, 0, 0, 1, 16'h0A47, "R7");
    step(0, 0, 0, 0, 1, 16'h7771, "R7");
    // random mix over a few groups
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] wk, rk;
      logic [2:0]  g1, g2;
      g1 = 3'($urandom_range(0, 3));
      g2 = 3'($urandom_range(0, 3));
      wk = {8'h3C, g1, 5'($urandom)};
      rk = (($urandom & 3) == 0) ? wk : {8'h3C, g2, 5'($urandom)};
      step(($urandom % 97) == 0, ($urandom & 1) == 1, wk, 10'($urandom),
           ($urandom % 3) != 0, rk, "R3/R6/R7 random");
    end
    idle(); idle(); idle();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: reads without result actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule